// File: doc/BRIEF.md
# Hex Text Command Line Parser

This block turns text lines typed or sent by a host into transmit frames for a contactless card reader. It receives one character per `rx_valid` pulse from a serial receiver. Each line holds two-digit hexadecimal byte tokens separated by spaces. Each character is checked as it arrives, and each completed byte is written into a line buffer. The buffer is released only once the line terminator shows that the whole line is well formed.

A released frame leaves on consecutive cycles, one byte per cycle, marked with first and last flags and a count of the bits that are valid in that byte. The final token may be written as `HH:n` so that only the low `n` bits of that byte go on air, which is needed for bit-oriented anticollision frames. No checksum appears in the text; a downstream stage appends it where the protocol needs it.

The block also drives the carrier enable. Every accepted line, including an empty one, reloads a keep-alive timer. The carrier drops by itself once the timer runs out, about 1.2 s at the default setting.

Top module: `hexline_cmd_parser`

## Requirements
- R1: The digits 0-9, A-F and a-f are accepted as hex digits, and the first digit of a token gives bits 7:4 of its byte. Every value 0x00-0xFF written in either case comes out unchanged.
- R2: A valid line with N byte tokens gives exactly N output beats in text order. `fr_first` is set only on the first beat and `fr_last` only on the last. Every beat other than a partial final byte carries `fr_nbits` = 8.
- R3: A final token `HH:n`, with n from 1 to 7, sets `fr_nbits` = n on the last beat, and `fr_data` keeps all eight written bits. A line is discarded if n is 0 or 8-9, if n is a letter, if n is missing, or if any byte token follows a partial byte.
- R4: A line ends at CR (0x0D), at LF (0x0A), or at CR followed by LF. The LF of a CR+LF pair produces no second command.
- R5: Any character other than a hex digit, space (0x20), colon (0x3A), CR or LF makes the whole line produce no output. Such a line does not turn on the carrier.
- R6: A line with a one-digit token, a token of three or more digits, or a colon not directly after two digits produces no output.
- R7: A line of exactly MAX_BYTES bytes is sent in full. A line of MAX_BYTES+1 bytes produces no output.
- R8: `carrier_en` rises on the cycle after the terminator of any accepted line. It stays high for exactly TIMEOUT_CYC cycles after the last accepted line and then falls.
- R9: An empty line produces no frame beat but restarts the carrier timer.
- R10: During and right after reset, `fr_valid`, `fr_first`, `fr_last` and `carrier_en` are low.
- R11: The first beat appears two cycles after the terminator is sampled, and the beats of one frame follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_char | input | 8 | Received ASCII character |
| fr_valid | output | 1 | Frame beat valid |
| fr_data | output | 8 | Frame byte |
| fr_nbits | output | 4 | Valid low bits of `fr_data` (1-8) |
| fr_first | output | 1 | First beat of a frame |
| fr_last | output | 1 | Last beat of a frame |
| carrier_en | output | 1 | Carrier enable with idle timeout |

## Verification
Faults in the token state machine are caught when the line ends. A lost digit count or colon flag either lets a malformed line through or drops a good one, which is seen two cycles after the terminator as an unexpected or missing frame. Faults in the buffer index or the length latch show up in the beat sequence of that same frame: a wrong byte, a missing last flag, or the wrong bit count. A faulty keep-alive counter is exposed at the exact cycle `carrier_en` falls, counted from the last accepted line.

// File: rtl/hexline_cmd_parser.sv
module hexline_cmd_parser #(
  parameter int MAX_BYTES = 32,
  parameter int unsigned TIMEOUT_CYC = 97_627_200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_char,
  output logic       fr_valid,
  output logic [7:0] fr_data,
  output logic [3:0] fr_nbits,
  output logic       fr_first,
  output logic       fr_last,
  output logic       carrier_en
);
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam int IW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [7:0]    line_mem [MAX_BYTES];
  logic [CW-1:0] wcnt, rlen;
  logic [IW-1:0] ridx;
  logic [3:0]    hi_nib, nib;
  logic [1:0]    ndig;
  logic          colon, bad, prev_cr, busy, is_hex;
  logic [2:0]    pbits, rpbits;
  logic [TW-1:0] tmr;

  wire is_cr  = rx_char == 8'h0D;
  wire is_lf  = rx_char == 8'h0A;
  wire is_sp  = rx_char == 8'h20;
  wire is_col = rx_char == 8'h3A;
  wire eol    = rx_valid && (is_cr || is_lf) && !(is_lf && prev_cr);
  wire eol_ok = !bad && ndig != 2'd1 && !(colon && pbits == 3'd0);
  wire wr_en  = rx_valid && is_hex && !colon && ndig == 2'd1 && wcnt < CW'(MAX_BYTES);
  wire rd_last = (CW'(ridx) + CW'(1)) == rlen;

  assign carrier_en = tmr != '0;

  always_comb begin
    is_hex = 1'b1;
    nib    = rx_char[3:0];
    if (rx_char >= 8'h30 && rx_char <= 8'h39) nib = rx_char[3:0];
    else if ((rx_char >= 8'h41 && rx_char <= 8'h46) || (rx_char >= 8'h61 && rx_char <= 8'h66))
      nib = rx_char[3:0] + 4'd9;
    else begin
      is_hex = 1'b0;
      nib    = 4'd0;
    end
  end

  always_ff @(posedge clk)
    if (wr_en) line_mem[wcnt[IW-1:0]] <= {hi_nib, nib};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0; hi_nib <= '0; ndig <= '0; colon <= 1'b0; pbits <= '0;
      bad <= 1'b0; prev_cr <= 1'b0; tmr <= '0;
    end else begin
      if (tmr != '0) tmr <= tmr - TW'(1);
      if (rx_valid) begin
        prev_cr <= is_cr;
        if (is_cr || is_lf) begin
          if (eol && eol_ok) tmr <= TW'(TIMEOUT_CYC);
          wcnt <= '0; ndig <= '0; colon <= 1'b0; pbits <= '0; bad <= 1'b0;
        end else if (is_sp) begin
          if (ndig == 2'd1 || (colon && pbits == 3'd0)) bad <= 1'b1;
          ndig <= '0;
        end else if (is_col) begin
          if (ndig != 2'd2 || colon) bad <= 1'b1;
          colon <= 1'b1;
        end else if (is_hex) begin
          if (colon) begin
            if (pbits == 3'd0 && ndig == 2'd2 && nib != 4'd0 && !nib[3]) pbits <= nib[2:0];
            else bad <= 1'b1;
          end else if (ndig == 2'd0) begin
            hi_nib <= nib;
            ndig   <= 2'd1;
          end else if (ndig == 2'd1) begin
            if (wcnt == CW'(MAX_BYTES)) bad <= 1'b1;
            else wcnt <= wcnt + CW'(1);
            ndig <= 2'd2;
          end else bad <= 1'b1;
        end else bad <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ridx <= '0; rlen <= '0; rpbits <= '0;
      fr_valid <= 1'b0; fr_data <= '0; fr_nbits <= '0; fr_first <= 1'b0; fr_last <= 1'b0;
    end else begin
      fr_valid <= busy;
      fr_first <= busy && ridx == '0;
      fr_last  <= busy && rd_last;
      if (busy) begin
        fr_data  <= line_mem[ridx];
        fr_nbits <= (rd_last && rpbits != 3'd0) ? {1'b0, rpbits} : 4'd8;
        ridx     <= ridx + IW'(1);
        if (rd_last) busy <= 1'b0;
      end
      if (eol && eol_ok && wcnt != '0) begin
        busy   <= 1'b1;
        ridx   <= '0;
        rlen   <= wcnt;
        rpbits <= pbits;
      end
    end
  end
endmodule

module hexline_cmd_parser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_char,
  input logic       fr_valid,
  input logic [3:0] fr_nbits,
  input logic       fr_first,
  input logic       fr_last,
  input logic       carrier_en
);
  AST_FIRST_IS_BEAT: assert property (@(posedge clk) disable iff (!rst_n) fr_first |-> fr_valid); // R2
  AST_LAST_IS_BEAT: assert property (@(posedge clk) disable iff (!rst_n) fr_last |-> fr_valid); // R2
  AST_NBITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) fr_valid |-> (fr_nbits >= 4'd1 && fr_nbits <= 4'd8)); // R3
  AST_FULL_BEFORE_LAST: assert property (@(posedge clk) disable iff (!rst_n) (fr_valid && !fr_last) |-> fr_nbits == 4'd8); // R3
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n) (fr_valid && !fr_last) |=> (fr_valid && !fr_first)); // R11
  AST_NEW_FRAME_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) fr_last |=> (!fr_valid || fr_first)); // R2
  AST_CARRIER_ON_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_en) |-> ($past(rx_valid) && ($past(rx_char) == 8'h0D || $past(rx_char) == 8'h0A))); // R8
endmodule

bind hexline_cmd_parser hexline_cmd_parser_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
  .fr_valid(fr_valid), .fr_nbits(fr_nbits), .fr_first(fr_first),
  .fr_last(fr_last), .carrier_en(carrier_en)
);

// File: tb/hexline_cmd_parser_tb_top.sv
module hexline_cmd_parser_tb_top;
  localparam int MAXB = 8;
  localparam int TMO  = 300;

  logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic fr_valid, fr_first, fr_last, carrier_en;
  logic [7:0] fr_data;
  logic [3:0] fr_nbits;

  int n_chk = 0, n_fail = 0, n_got = 0;
  logic [7:0] gb [16];
  logic [3:0] gn [16];
  logic       gf [16];
  logic       gl [16];
  logic [7:0] exp_b [16];

  always #5 clk = ~clk;

  hexline_cmd_parser #(.MAX_BYTES(MAXB), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .fr_valid(fr_valid), .fr_data(fr_data), .fr_nbits(fr_nbits),
    .fr_first(fr_first), .fr_last(fr_last), .carrier_en(carrier_en));

  always @(negedge clk) if (fr_valid) begin
    if (n_got < 16) begin
      gb[n_got] = fr_data; gn[n_got] = fr_nbits; gf[n_got] = fr_first; gl[n_got] = fr_last;
    end
    n_got++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // term: 0 = LF, 1 = CR, 2 = CR+LF; returns one negedge after the last character
  task automatic send_line(input string s, input int term);
    int total = s.len() + ((term == 2) ? 2 : 1);
    n_got = 0;
    for (int i = 0; i < total; i++) begin
      logic [7:0] c;
      if (i < s.len()) c = s[i];
      else if (term == 0) c = 8'h0A;
      else if (term == 1) c = 8'h0D;
      else c = (i == s.len()) ? 8'h0D : 8'h0A;
      rx_valid = 1'b1; rx_char = c;
      @(negedge clk);
      rx_valid = 1'b0;
      if (i != total - 1) repeat (2) @(negedge clk);
    end
  endtask

  task automatic expect_none(input string s, input string req);
    send_line(s, 0);
    repeat (MAXB + 4) @(negedge clk);
    chk(n_got == 0, req, n_got, 0);
  endtask

  // frame text is built from exp_b; lastbits < 8 writes the last token as HH:n
  task automatic run_frame(input int n, input int lastbits, input int term, input string req);
    string s = "";
    for (int i = 0; i < n; i++) begin
      s = {s, (i % 2) ? $sformatf("%02x", exp_b[i]) : $sformatf("%02X", exp_b[i])};
      if (i == n - 1 && lastbits < 8) s = {s, $sformatf(":%0d", lastbits)};
      if (i != n - 1) s = {s, " "};
    end
    send_line(s, term);
    if (term == 0) begin
      chk(!fr_valid, "R11 no beat one cycle after terminator", fr_valid, 0);
      @(negedge clk);
      chk(fr_valid && fr_first && fr_data == exp_b[0], "R11 first beat two cycles after terminator", fr_data, exp_b[0]);
    end
    repeat (MAXB + 4) @(negedge clk);
    chk(n_got == n, {req, " beat count"}, n_got, n);
    for (int i = 0; i < n && i < 16; i++) begin
      int eb = (i == n - 1) ? lastbits : 8;
      chk(gb[i] == exp_b[i] && gf[i] == (i == 0) && gl[i] == (i == n - 1) && gn[i] == eb,
          {req, $sformatf(" beat %0d data/first/last/nbits", i)},
          {gb[i], 3'b0, gf[i], 3'b0, gl[i], gn[i]},
          {exp_b[i], 3'b0, 1'(i == 0), 3'b0, 1'(i == n - 1), 4'(eb)});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!fr_valid && !fr_first && !fr_last && !carrier_en, "R10 outputs low in reset",
        {fr_valid, fr_first, fr_last, carrier_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!fr_valid && !carrier_en, "R10 outputs low after reset", {fr_valid, carrier_en}, 0);

    // R1: sweep every byte value, alternating digit case
    for (int v = 0; v < 256; v++) begin
      send_line((v % 2) ? $sformatf("%02x", v) : $sformatf("%02X", v), 0);
      repeat (5) @(negedge clk);
      chk(n_got == 1 && gb[0] == 8'(v) && gf[0] && gl[0] && gn[0] == 4'd8,
          "R1 single byte value", gb[0], v);
    end

    // R2: multi-byte frames
    for (int n = 2; n <= 7; n++) begin
      for (int i = 0; i < n; i++) exp_b[i] = 8'((i * 73 + n * 29 + 17) % 256);
      run_frame(n, 8, 0, "R2 frame order");
    end

    // R3: partial final byte, every legal bit count
    for (int b = 1; b <= 7; b++) begin
      exp_b[0] = 8'h93; exp_b[1] = 8'(8'h20 + b); exp_b[2] = 8'((b * 37) % 256);
      run_frame(3, b, 0, "R3 partial last byte");
    end
    expect_none("93 22 03:0", "R3 bit count zero discarded");
    expect_none("93 22 03:8", "R3 bit count eight discarded");
    expect_none("93 22 03:9", "R3 bit count nine discarded");
    expect_none("93 22 03:a", "R3 letter bit count discarded");
    expect_none("93 22 03:", "R3 missing bit count discarded");
    expect_none("93 03:2 05", "R3 byte after partial discarded");
    expect_none("93 03:25", "R3 two-digit bit count discarded");

    // R4: terminators
    exp_b[0] = 8'h93; exp_b[1] = 8'h20;
    run_frame(2, 8, 1, "R4 CR terminator");
    run_frame(2, 8, 2, "R4 CR+LF single frame");
    exp_b[0] = 8'h26;
    run_frame(1, 8, 0, "R4 LF after CR+LF line");

    // R5 / R6: bad characters and malformed tokens
    expect_none("9G 20", "R5 bad letter discarded");
    expect_none("93-20", "R5 dash discarded");
    expect_none("9 20", "R6 one-digit token discarded");
    expect_none("932 0", "R6 three-digit token discarded");
    expect_none("93 2:1", "R6 colon after one digit discarded");
    expect_none(":1", "R6 leading colon discarded");

    // R7: buffer limit
    for (int i = 0; i < MAXB; i++) exp_b[i] = 8'(8'hA0 + i);
    run_frame(MAXB, 8, 0, "R7 exactly full line");
    expect_none("01 02 03 04 05 06 07 08 09", "R7 overflow line discarded");

    // R8 / R9 / R5: carrier keep-alive
    repeat (TMO + 10) @(negedge clk);
    chk(!carrier_en, "R8 carrier idle off", carrier_en, 0);
    send_line("zz", 0);
    repeat (4) @(negedge clk);
    chk(!carrier_en, "R5 invalid line leaves carrier off", carrier_en, 0);
    send_line("26", 0);
    chk(carrier_en, "R8 carrier rises after terminator", carrier_en, 1);
    repeat (TMO - 1) @(negedge clk);
    chk(carrier_en, "R8 carrier held to last cycle", carrier_en, 1);
    @(negedge clk);
    chk(!carrier_en, "R8 carrier off after timeout", carrier_en, 0);

    send_line("", 0);
    chk(carrier_en, "R9 empty line turns carrier on", carrier_en, 1);
    repeat (100) @(negedge clk);
    chk(n_got == 0, "R9 empty line gives no beat", n_got, 0);
    send_line("", 0);
    repeat (TMO - 1) @(negedge clk);
    chk(carrier_en, "R9 empty line restarts timer", carrier_en, 1);
    @(negedge clk);
    chk(!carrier_en, "R9 off after restarted timeout", carrier_en, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule